// File: doc/BRIEF.md
# Parallel Converter Readout Sequencer

This block runs a 12-bit sampling converter from the host side. The converter sits on a shared 8-bit three-state bus. The block drives the chip-select, write, read and high-byte-enable strobes from the system clock. A one-cycle `start` request makes it write a control byte, which selects the channel, range, polarity and power mode. It then waits for the converter's active-low completion line. Two read cycles follow: the low eight result bits first, then the upper nibble. The block returns the assembled word widened to 16 bits, with a one-cycle `done` pulse.

Two acquisition styles are offered. In the short one, a single write starts the sampling window and the conversion. In the long one, a first write opens an acquisition window that lasts `ACQ_CYC` clocks, and a second write closes it. Every strobe width and every gap is a clock count. These counts are rounded up from nanosecond limits, and those limits are parameters.

The upper read also returns four padding bits. The block checks them against the polarity it requested. It also gives up on a conversion that never reports completion.

Top module: `adc_bus_host`

## Requirements
- R1: After reset, `cs_n`, `wr_n` and `rd_n` are high, `hben` is low, `bus_oe` is 0 and `done` is 0.
- R2: With `ext_acq`=0, a start issues exactly one write cycle. The byte on `bus_out` is `cfg_byte` with bit 5 forced to 0, and `wr_n` stays low for at least WR_CYC clocks.
- R3: With `ext_acq`=1, a start issues two write cycles. The first byte is `cfg_byte` with bit 5 set and the second is `cfg_byte` with bit 5 cleared, so all other bits are identical. The strobes stay high between the two writes.
- R4: `bus_oe` is 1 throughout each write strobe and is 0 whenever `rd_n` is low.
- R5: No read starts before the synchronised `irq_n` is low. Two reads follow in order: the first with `hben`=0, the second with `hben`=1. Each holds `rd_n` low for at least RD_CYC clocks, `hben` does not change while `rd_n` is low, and `rd_n` stays high for at least REL_CYC clocks between them.
- R6: When bit 3 of the control byte is 1 (bipolar), `result` is the 12-bit two's-complement sample sign-extended from bit 11. The sample is formed as {upper-read bits 3..0, lower-read bits 7..0}.
- R7: When bit 3 is 0 (unipolar), `result` is that 12-bit sample zero-extended.
- R8: `err_nibble` is 1 with `done` when upper-read bits 7..4 are not all equal to sample bit 11 (bipolar), or are not all zero (unipolar). Otherwise it is 0.
- R9: If `irq_n` is not seen low within TIMEOUT_CYC clocks of waiting, the block pulses `done` with `err_timeout`=1. It issues no read and leaves `result` unchanged.
- R10: `done` lasts exactly one clock, and `result` changes only in a cycle where `done` is 1.
- R11: A `start` while a transaction is in progress is ignored: it issues no extra write and does not change the bytes written.
- R12: `cs_n` is low whenever `wr_n` or `rd_n` is low, and `wr_n` and `rd_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle conversion request, sampled when idle |
| cfg_byte | input | 8 | Control byte; bit 5 selects acquisition style, bit 3 polarity |
| ext_acq | input | 1 | 1 = two-write long acquisition |
| bus_in | input | 8 | Data bus as seen by the host |
| bus_out | output | 8 | Byte the host drives during writes |
| bus_oe | output | 1 | Host output enable for the bus |
| cs_n | output | 1 | Chip select, active low |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| hben | output | 1 | High-byte enable for the second read |
| irq_n | input | 1 | Converter completion line, active low, asynchronous |
| result | output | 16 | Widened conversion result |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Completion line never fell |
| err_nibble | output | 1 | Upper padding bits disagree with polarity |

## Verification
The assertions watch the bus etiquette on every cycle:
- the strobe pairing and the chip-select cover;
- no host drive during a read, and drive throughout a write;
- minimum write and read strobe widths, and a steady `hben` within a read;
- the single-cycle `done` and the hold of `result`.

Only the bench scenarios can show the contents of the transaction. That covers the exact bytes written in each acquisition style, that sampling waits for converter data, sign versus zero extension, detection of corrupted padding bits, the timeout path, and that a start raised while busy is ignored.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_WRITE, S_WGAP, S_ACQ, S_WAIT, S_RDLO, S_RGAP, S_RDHI, S_TAIL
  } host_st_t;

  // clock cycles covering a time limit, rounded up
  function automatic int cyc_ceil(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ahb_timer.sv
module ahb_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/ahb_unpack.sv
module ahb_unpack (
  input  logic [7:0]  lo,
  input  logic [7:0]  hi,
  input  logic        bip,
  output logic [15:0] word,
  output logic        bad
);
  logic [11:0] smp;
  logic [3:0]  pad_exp;

  always_comb begin
    smp     = {hi[3:0], lo};
    pad_exp = bip ? {4{hi[3]}} : 4'b0000;
    word    = {pad_exp, smp};
    bad     = (hi[7:4] != pad_exp);
  end
endmodule

// File: rtl/adc_bus_host.sv
module adc_bus_host
  import adc_host_pkg::*;
#(
  parameter int CLK_NS       = 20,
  parameter int T_STROBE_NS  = 80,
  parameter int T_DSETUP_NS  = 60,
  parameter int T_ACCESS_NS  = 120,
  parameter int T_RELEASE_NS = 70,
  parameter int ACQ_CYC      = 10,
  parameter int TIMEOUT_CYC  = 1000,
  parameter int SYNC_LEN     = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [7:0]  cfg_byte,
  input  logic        ext_acq,
  input  logic [7:0]  bus_in,
  output logic [7:0]  bus_out,
  output logic        bus_oe,
  output logic        cs_n,
  output logic        wr_n,
  output logic        rd_n,
  output logic        hben,
  input  logic        irq_n,
  output logic [15:0] result,
  output logic        done,
  output logic        err_timeout,
  output logic        err_nibble
);
  localparam int WR_CYC  = imax(1, imax(cyc_ceil(T_STROBE_NS, CLK_NS), cyc_ceil(T_DSETUP_NS, CLK_NS)));
  localparam int RD_CYC  = imax(1, cyc_ceil(T_ACCESS_NS, CLK_NS));
  localparam int REL_CYC = imax(1, cyc_ceil(T_RELEASE_NS, CLK_NS));
  localparam int ACQ_N   = imax(1, ACQ_CYC);
  localparam int CMAX    = imax(imax(WR_CYC, RD_CYC), imax(REL_CYC, ACQ_N));
  localparam int CW      = imax(1, $clog2(CMAX + 1));
  localparam int TW      = imax(1, $clog2(TIMEOUT_CYC + 1));
  localparam logic [CW-1:0] L_WR  = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] L_RD  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] L_REL = CW'(REL_CYC - 1);
  localparam logic [CW-1:0] L_ACQ = CW'(ACQ_N - 1);
  localparam logic [TW-1:0] L_TMO = TW'(TIMEOUT_CYC - 1);
  localparam logic [7:0]    ACQ_BIT = 8'h20;

  // completion line synchroniser
  logic irq_s;
  generate
    if (SYNC_LEN == 0) begin : g_nosync
      assign irq_s = irq_n;
    end else begin : g_sync
      logic [SYNC_LEN-1:0] sq;
      always_ff @(posedge clk) begin
        if (rst) sq <= '1;
        else     sq <= {sq[SYNC_LEN-2:0], irq_n};
      end
      assign irq_s = sq[SYNC_LEN-1];
    end
  endgenerate

  host_st_t      st, st_n;
  logic          cs_r, wr_r, rd_r, hb_r, oe_r, done_r, et_r, en_r, sec_r;
  logic          cs_x, wr_x, rd_x, hb_x, oe_x, done_x, et_x, en_x, sec_x;
  logic [7:0]    dout_r, dout_x, cfg_r, cfg_x, lo_r, lo_x;
  logic [15:0]   res_r, res_x;
  logic [TW-1:0] tmo_r, tmo_x;
  logic          ld, t_zero;
  logic [CW-1:0] ldv;
  logic [15:0]   u_word;
  logic          u_bad;

  ahb_timer #(.W(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(ld), .val(ldv), .zero(t_zero)
  );

  ahb_unpack u_unp (
    .lo(lo_r), .hi(bus_in), .bip(cfg_r[3]), .word(u_word), .bad(u_bad)
  );

  always_comb begin
    st_n = st;  cs_x = cs_r; wr_x = wr_r; rd_x = rd_r; hb_x = hb_r;
    oe_x = oe_r; dout_x = dout_r; cfg_x = cfg_r; lo_x = lo_r; res_x = res_r;
    et_x = et_r; en_x = en_r; sec_x = sec_r; tmo_x = tmo_r;
    done_x = 1'b0; ld = 1'b0; ldv = '0;
    unique case (st)
      S_IDLE: if (start) begin
        cfg_x  = cfg_byte;
        sec_x  = ext_acq;
        dout_x = ext_acq ? (cfg_byte | ACQ_BIT) : (cfg_byte & ~ACQ_BIT);
        oe_x = 1'b1; cs_x = 1'b0; wr_x = 1'b0;
        et_x = 1'b0; en_x = 1'b0;
        ld = 1'b1; ldv = L_WR; st_n = S_WRITE;
      end
      S_WRITE: if (t_zero) begin
        wr_x = 1'b1; cs_x = 1'b1;
        ld = 1'b1; ldv = L_REL; st_n = S_WGAP;
      end
      S_WGAP: if (t_zero) begin
        oe_x = 1'b0;
        if (sec_r) begin
          ld = 1'b1; ldv = L_ACQ; st_n = S_ACQ;
        end else begin
          tmo_x = '0; st_n = S_WAIT;
        end
      end
      S_ACQ: if (t_zero) begin
        dout_x = cfg_r & ~ACQ_BIT;
        oe_x = 1'b1; cs_x = 1'b0; wr_x = 1'b0; sec_x = 1'b0;
        ld = 1'b1; ldv = L_WR; st_n = S_WRITE;
      end
      S_WAIT: begin
        if (!irq_s) begin
          cs_x = 1'b0; rd_x = 1'b0; hb_x = 1'b0;
          ld = 1'b1; ldv = L_RD; st_n = S_RDLO;
        end else if (tmo_r == L_TMO) begin
          et_x = 1'b1; done_x = 1'b1; st_n = S_IDLE;
        end else begin
          tmo_x = tmo_r + 1'b1;
        end
      end
      S_RDLO: if (t_zero) begin
        lo_x = bus_in; rd_x = 1'b1; cs_x = 1'b1;
        ld = 1'b1; ldv = L_REL; st_n = S_RGAP;
      end
      S_RGAP: if (t_zero) begin
        cs_x = 1'b0; rd_x = 1'b0; hb_x = 1'b1;
        ld = 1'b1; ldv = L_RD; st_n = S_RDHI;
      end
      S_RDHI: if (t_zero) begin
        res_x = u_word; en_x = u_bad; done_x = 1'b1;
        rd_x = 1'b1; cs_x = 1'b1; hb_x = 1'b0;
        ld = 1'b1; ldv = L_REL; st_n = S_TAIL;
      end
      S_TAIL: if (t_zero) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      cs_r <= 1'b1; wr_r <= 1'b1; rd_r <= 1'b1; hb_r <= 1'b0; oe_r <= 1'b0;
      dout_r <= '0; cfg_r <= '0; lo_r <= '0; res_r <= '0;
      done_r <= 1'b0; et_r <= 1'b0; en_r <= 1'b0; sec_r <= 1'b0; tmo_r <= '0;
    end else begin
      st <= st_n;
      cs_r <= cs_x; wr_r <= wr_x; rd_r <= rd_x; hb_r <= hb_x; oe_r <= oe_x;
      dout_r <= dout_x; cfg_r <= cfg_x; lo_r <= lo_x; res_r <= res_x;
      done_r <= done_x; et_r <= et_x; en_r <= en_x; sec_r <= sec_x; tmo_r <= tmo_x;
    end
  end

  assign bus_out     = dout_r;
  assign bus_oe      = oe_r;
  assign cs_n        = cs_r;
  assign wr_n        = wr_r;
  assign rd_n        = rd_r;
  assign hben        = hb_r;
  assign result      = res_r;
  assign done        = done_r;
  assign err_timeout = et_r;
  assign err_nibble  = en_r;
endmodule

// File: rtl/adc_bus_host_chk.sv
module adc_bus_host_chk #(
  parameter int WR_MIN = 1,
  parameter int RD_MIN = 1
) (
  input logic        clk,
  input logic        rst,
  input logic        cs_n,
  input logic        wr_n,
  input logic        rd_n,
  input logic        hben,
  input logic        bus_oe,
  input logic        done,
  input logic [15:0] result
);
  logic [15:0] wr_run, rd_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_run <= '0; rd_run <= '0;
    end else begin
      wr_run <= !wr_n ? ((wr_run == 16'hFFFF) ? wr_run : wr_run + 1'b1) : '0;
      rd_run <= !rd_n ? ((rd_run == 16'hFFFF) ? rd_run : rd_run + 1'b1) : '0;
    end
  end

  assert_strobe_cs_R12: assert property (@(posedge clk) disable iff (rst)
    (!wr_n || !rd_n) |-> !cs_n);
  assert_wr_rd_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(!wr_n && !rd_n));
  assert_no_drive_read_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !bus_oe);
  assert_drive_write_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> bus_oe);
  assert_wr_width_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> (wr_run >= 16'(WR_MIN)));
  assert_rd_width_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_n) |-> (rd_run >= 16'(RD_MIN)));
  assert_hben_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && $past(!rd_n)) |-> $stable(hben));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);
endmodule

bind adc_bus_host adc_bus_host_chk #(.WR_MIN(WR_CYC), .RD_MIN(RD_CYC)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .hben(hben),
  .bus_oe(bus_oe), .done(done), .result(result)
);

// File: tb/sim_adc_bus_host.sv
module sim_adc_bus_host;
  localparam int TMO    = 60;
  localparam int ACQ    = 10;
  localparam int CONV   = 20;
  localparam int DVALID = 5;
  localparam int WR_EXP = 4;
  localparam int RD_EXP = 6;
  localparam int REL_EXP = 4;

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0, ext_acq = 1'b0;
  logic [7:0]  cfg_byte = '0, bus_in = '0, bus_out;
  logic        bus_oe, cs_n, wr_n, rd_n, hben, done, err_timeout, err_nibble;
  logic        irq_m = 1'b1;
  logic [15:0] result;

  adc_bus_host #(.ACQ_CYC(ACQ), .TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst(rst), .start(start), .cfg_byte(cfg_byte), .ext_acq(ext_acq),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .cs_n(cs_n), .wr_n(wr_n),
    .rd_n(rd_n), .hben(hben), .irq_n(irq_m), .result(result), .done(done),
    .err_timeout(err_timeout), .err_nibble(err_nibble)
  );

  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model and bus monitor, all at the falling edge
  logic [11:0] smp = '0;
  bit          corrupt = 0, noresp = 0, bip_m = 0;
  bit          prev_wr = 1, prev_rd = 1;
  logic [7:0]  wr_byte = '0;
  int          wr_w = 0, rd_w = 0, gap = 0, conv_cnt = 0, nreads = 0, viol = 0;
  int          wr_min = 999, rd_min = 999, gap_min = 999;
  logic [7:0]  writes[$];
  bit          rd_hb[$];

  always @(negedge clk) begin
    if (rst) begin
      prev_wr = 1; prev_rd = 1; irq_m = 1; bus_in = 8'h00; conv_cnt = 0;
    end else begin
      if (bus_oe && !rd_n) viol++;
      if ((!wr_n || !rd_n) && cs_n) viol++;
      if (!wr_n && !rd_n) viol++;
      if (!wr_n) begin
        wr_w++; wr_byte = bus_out;
      end else if (!prev_wr) begin
        writes.push_back(wr_byte);
        if (wr_w < wr_min) wr_min = wr_w;
        wr_w = 0; irq_m = 1;
        if (!wr_byte[5]) begin bip_m = wr_byte[3]; conv_cnt = CONV; end
      end
      if (conv_cnt > 0) begin
        conv_cnt--;
        if (conv_cnt == 0 && !noresp) irq_m = 0;
      end
      if (!rd_n && !cs_n) begin
        if (prev_rd) begin
          rd_hb.push_back(hben); irq_m = 1;
          if (nreads > 0 && gap < gap_min) gap_min = gap;
          nreads++;
        end
        rd_w++;
        if (rd_w >= DVALID) begin
          if (hben) begin
            bus_in = {(bip_m ? {4{smp[11]}} : 4'b0000), smp[11:8]};
            if (corrupt) bus_in[6] = ~bus_in[6];
          end else bus_in = smp[7:0];
        end else bus_in = 8'hEE;
      end else begin
        if (!prev_rd) begin
          if (rd_w < rd_min) rd_min = rd_w;
          rd_w = 0; gap = 0;
        end
        gap++; bus_in = 8'h00;
      end
      prev_wr = wr_n; prev_rd = rd_n;
    end
  end

  task automatic run(input logic [7:0] cfg, input bit ext, input logic [11:0] s,
                     input bit cor, input bit nr, input bit busy_start);
    logic [15:0] prev_res, exp;
    int w;
    bit bip;
    prev_res = result;
    smp = s; corrupt = cor; noresp = nr;
    writes.delete(); rd_hb.delete();
    wr_min = 999; rd_min = 999; gap_min = 999; nreads = 0;
    @(negedge clk);
    start = 1; cfg_byte = cfg; ext_acq = ext;
    @(negedge clk);
    start = 0;
    if (busy_start) begin
      repeat (3) @(negedge clk);
      start = 1; cfg_byte = 8'h47; ext_acq = 1;
      @(negedge clk);
      start = 0; cfg_byte = cfg; ext_acq = ext;
    end
    w = 0;
    while (!done && w < 3000) begin @(negedge clk); w++; end
    chk(w < 3000, "watchdog", w, 0);
    bip = cfg[3];
    exp = bip ? {{4{s[11]}}, s} : {4'b0000, s};
    // R2 / R3 / R11: bytes written
    chk(writes.size() == (ext ? 2 : 1), "R2 R3 R11 write count", writes.size(), ext ? 2 : 1);
    if (writes.size() >= 1)
      chk(writes[0] == (ext ? (cfg | 8'h20) : (cfg & 8'hDF)), "R2 R3 first byte", writes[0],
          ext ? (cfg | 8'h20) : (cfg & 8'hDF));
    if (ext && writes.size() >= 2)
      chk(writes[1] == (cfg & 8'hDF), "R3 second byte", writes[1], cfg & 8'hDF);
    chk(wr_min >= WR_EXP, "R2 write width", wr_min, WR_EXP);
    if (nr) begin
      chk(err_timeout == 1'b1, "R9 timeout flag", err_timeout, 1);
      chk(rd_hb.size() == 0, "R9 no read", rd_hb.size(), 0);
      chk(result == prev_res, "R9 result kept", result, prev_res);
    end else begin
      chk(err_timeout == 1'b0, "R9 no timeout", err_timeout, 0);
      chk(result == exp, bip ? "R6 bipolar result" : "R7 unipolar result", result, exp);
      chk(err_nibble == cor, "R8 nibble check", err_nibble, cor);
      chk(rd_hb.size() == 2 && rd_hb[0] == 1'b0 && rd_hb[1] == 1'b1, "R5 read order",
          rd_hb.size(), 2);
      chk(rd_min >= RD_EXP, "R5 read width", rd_min, RD_EXP);
      chk(gap_min >= REL_EXP, "R5 read gap", gap_min, REL_EXP);
    end
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({cs_n, wr_n, rd_n, hben, bus_oe, done} == 6'b111000, "R1 reset state",
        {cs_n, wr_n, rd_n, hben, bus_oe, done}, 6'b111000);
    rst = 0;
    @(negedge clk);
    chk({cs_n, wr_n, rd_n, hben, bus_oe, done} == 6'b111000, "R1 idle after reset",
        {cs_n, wr_n, rd_n, hben, bus_oe, done}, 6'b111000);
    run(8'h02, 0, 12'hABC, 0, 0, 0);   // R7 unipolar, R2
    run(8'h0D, 0, 12'h9F3, 0, 0, 0);   // R6 negative bipolar
    run(8'h18, 0, 12'h7FF, 0, 0, 0);   // R6 positive bipolar
    run(8'h22, 0, 12'h00F, 0, 0, 1);   // R2 bit5 cleared, R11 busy start
    run(8'h0B, 1, 12'h800, 0, 0, 0);   // R3 two-write acquisition
    run(8'h09, 0, 12'h123, 1, 0, 0);   // R8 bipolar pad disagreement
    run(8'h01, 1, 12'hFFF, 1, 0, 0);   // R8 unipolar non-zero pad
    run(8'h0C, 0, 12'h456, 0, 1, 0);   // R9 timeout
    run(8'h05, 0, 12'h321, 0, 0, 0);   // R7 recovery after timeout
    chk(viol == 0, "R4 R12 bus etiquette", viol, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule